// File: doc/BRIEF.md
# Management-Port PHY Register Responder

This block stands in for the register file of one Ethernet PHY as a host sees it through a single 32-bit management command register. The host writes a command word. It carries a read/write flag, a register number and 16 bits of write data. One clock later the block carries out the access. On a read, it overwrites the stored command word with the zero-extended 16-bit result. On a read or a write, it sets a completion flag that stays set until the host clears it.

Inside are a control register, a status register, an advertisement register, an interrupt-source register and an interrupt-mask register. Fixed identification and partner-ability words are decoded directly. A link-up input is edge-detected. Each transition updates the link and auto-negotiation status bits and posts interrupt-source bits. An interrupt output reflects the masked interrupt sources. Auto-negotiation completes at once when the host requests it. Serial bit timing is not modelled.

Top module: `mgmt_phy_regs`

## Requirements
- R1: Command word fields: bit 29 = 1 selects a read and 0 selects a write, bits 27..18 give the register number, and bits 15..0 give the write data. After a write, the command word reads back unchanged, and it stays unchanged while no command is pending.
- R2: A command accepted on a `cmdWe` clock completes on the following clock. `doneFlag` becomes 1 at that point, and on a read `cmdRdata` becomes {16'h0, value} at the same point. `doneFlag` stays 1 until a cycle with `doneClr` = 1 and no completion.
- R3: After reset, register 0 reads 0x3000, register 1 reads 0x7809, register 4 reads 0x01E1 and register 30 reads 0x0000. `doneFlag`, `cmdRdata` and `phyIrq` are 0 while reset is held.
- R4: Register 2 reads 0x0007, register 3 reads 0xC0D1, register 5 reads 0x0F71 and register 6 reads 0x0001.
- R5: Register numbers above 31 read 0 and ignore writes; they do not alias onto registers 0..31. Registers 17, 18, 27, 31 and every other number not listed in R3, R4 or R8 also read 0 and ignore writes.
- R6: A write to register 0 with data bit 15 = 1 returns every register to its R3 value, and the link input is evaluated again on the next clock. A write without bit 15 stores data AND 0x7980. If data bit 12 is set, it also sets status bit 5.
- R7: A write to register 4 stores (data AND 0x2D7F) OR 0x0080. A write to register 30 stores data AND 0x00FF.
- R8: A read of register 29 returns the interrupt-source bits and clears them. Bits posted by a link change in that same clock are kept.
- R9: On a rising link input, status bits 2 and 5 are set and interrupt-source bits 7 and 6 are set. On a falling link input, status bits 2 and 5 are cleared and interrupt-source bit 4 is set. Each transition posts its bits once. The link state is also evaluated on the first clock after reset.
- R10: `phyIrq` is 1 exactly when (interrupt source AND interrupt mask) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWe | input | 1 | Command register write strobe |
| cmdWdata | input | 32 | Command word written by the host |
| cmdRdata | output | 32 | Stored command word, replaced by read results |
| doneFlag | output | 1 | Sticky management-complete flag |
| doneClr | input | 1 | Clears the completion flag |
| linkUp | input | 1 | Link state from the line side |
| phyIrq | output | 1 | PHY interrupt request |

## Verification
A command driven on one clock is captured on that edge and executed on the next edge. The completion flag and any read result are therefore due two rising edges after the strobe is raised. Interrupt-source and status updates from a link change show up on the first rising edge that samples the new link level. `phyIrq` follows on that same edge. The bench drives inputs on falling edges and samples each result on the falling edge after its edge is due. Its scoreboard pops the expected command-register value only when the completion flag first reads set.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;
  localparam int CMD_W     = 32;
  localparam int DATA_W    = 16;
  localparam int REGNUM_W  = 10;
  localparam int RD_BIT    = 29;
  localparam int REG_LSB   = 18;
  localparam int REG_MSB   = REG_LSB + REGNUM_W - 1;

  localparam logic [DATA_W-1:0] CTRL_RST  = 16'h3000;
  localparam logic [DATA_W-1:0] STAT_RST  = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_RST   = 16'h01E1;
  localparam logic [DATA_W-1:0] CTRL_MASK = 16'h7980;
  localparam logic [DATA_W-1:0] ADV_MASK  = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_FORCE = 16'h0080;
  localparam logic [DATA_W-1:0] IMSK_MASK = 16'h00FF;
  localparam logic [DATA_W-1:0] LINK_STAT = 16'h0024;
  localparam logic [DATA_W-1:0] ANEG_DONE = 16'h0020;
  localparam logic [DATA_W-1:0] INT_UP    = 16'h00C0;
  localparam logic [DATA_W-1:0] INT_DOWN  = 16'h0010;

  // register numbers whose position is decoded by host software
  localparam logic [REGNUM_W-1:0] RN_CTRL = 10'd0;
  localparam logic [REGNUM_W-1:0] RN_STAT = 10'd1;
  localparam logic [REGNUM_W-1:0] RN_ID1  = 10'd2;
  localparam logic [REGNUM_W-1:0] RN_ID2  = 10'd3;
  localparam logic [REGNUM_W-1:0] RN_ADV  = 10'd4;
  localparam logic [REGNUM_W-1:0] RN_LPA  = 10'd5;
  localparam logic [REGNUM_W-1:0] RN_EXP  = 10'd6;
  localparam logic [REGNUM_W-1:0] RN_ISRC = 10'd29;
  localparam logic [REGNUM_W-1:0] RN_IMSK = 10'd30;

  typedef struct packed {
    logic                phyReset;
    logic                wrCtrl;
    logic                wrAdv;
    logic                wrMask;
    logic                clrInt;
    logic [REGNUM_W-1:0] regSel;
    logic [DATA_W-1:0]   data;
  } mgmtStrobes_t;
endpackage

// File: rtl/mgmt_phy_ctrl.sv
module mgmt_phy_ctrl
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWe,
  input  logic [CMD_W-1:0]  cmdWdata,
  input  logic              doneClr,
  input  logic [DATA_W-1:0] rdVal,
  output mgmtStrobes_t      stb,
  output logic [CMD_W-1:0]  cmdReg,
  output logic              doneFlag
);
  logic pending;
  logic isRead;
  logic [REGNUM_W-1:0] regNum;
  logic [DATA_W-1:0]   wrData;
  logic doWrite;

  // R1 field decode
  assign isRead  = cmdReg[RD_BIT];
  assign regNum  = cmdReg[REG_MSB:REG_LSB];
  assign wrData  = cmdReg[DATA_W-1:0];
  assign doWrite = pending && !isRead;

  always_comb begin
    stb          = '0;
    stb.regSel   = regNum;
    stb.data     = wrData;
    stb.phyReset = doWrite && (regNum == RN_CTRL) && wrData[15];   // R6
    stb.wrCtrl   = doWrite && (regNum == RN_CTRL) && !wrData[15];
    stb.wrAdv    = doWrite && (regNum == RN_ADV);                  // R7
    stb.wrMask   = doWrite && (regNum == RN_IMSK);
    stb.clrInt   = pending && isRead && (regNum == RN_ISRC);       // R8
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      pending  <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (cmdWe) begin
        cmdReg  <= cmdWdata;
        pending <= 1'b1;
      end else begin
        pending <= 1'b0;
        if (pending && isRead) cmdReg <= {{(CMD_W-DATA_W){1'b0}}, rdVal}; // R2
      end
      if (pending)      doneFlag <= 1'b1;                                // R2
      else if (doneClr) doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/mgmt_phy_dp.sv
module mgmt_phy_dp
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mgmtStrobes_t      stb,
  input  logic              linkUp,
  output logic [DATA_W-1:0] rdVal,
  output logic              phyIrq
);
  logic [DATA_W-1:0] ctrlReg, statReg, advReg, maskReg, intReg;
  logic [DATA_W-1:0] ctrlN, statN, advN, maskN, intN;
  logic linkPrev, forceEval, linkEvt;

  // R4 R5 read decode; everything not listed reads zero
  always_comb begin
    case (stb.regSel)
      RN_CTRL: rdVal = ctrlReg;
      RN_STAT: rdVal = statReg;
      RN_ID1:  rdVal = 16'h0007;
      RN_ID2:  rdVal = 16'hC0D1;
      RN_ADV:  rdVal = advReg;
      RN_LPA:  rdVal = 16'h0F71;
      RN_EXP:  rdVal = 16'h0001;
      RN_ISRC: rdVal = intReg;
      RN_IMSK: rdVal = maskReg;
      default: rdVal = '0;
    endcase
  end

  assign linkEvt = forceEval || (linkUp != linkPrev);

  always_comb begin
    ctrlN = ctrlReg;
    statN = statReg;
    advN  = advReg;
    maskN = maskReg;
    intN  = stb.clrInt ? '0 : intReg;                 // R8
    if (stb.wrCtrl) begin                             // R6
      ctrlN = stb.data & CTRL_MASK;
      if (stb.data[12]) statN = statN | ANEG_DONE;
    end
    if (stb.wrAdv)  advN  = (stb.data & ADV_MASK) | ADV_FORCE; // R7
    if (stb.wrMask) maskN = stb.data & IMSK_MASK;
    if (linkEvt) begin                                // R9
      if (linkUp) begin
        statN = statN | LINK_STAT;
        intN  = intN | INT_UP;
      end else begin
        statN = statN & ~LINK_STAT;
        intN  = intN | INT_DOWN;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= CTRL_RST;
      statReg   <= STAT_RST;
      advReg    <= ADV_RST;
      maskReg   <= '0;
      intReg    <= '0;
      linkPrev  <= 1'b0;
      forceEval <= 1'b1;
    end else if (stb.phyReset) begin
      ctrlReg   <= CTRL_RST;
      statReg   <= STAT_RST;
      advReg    <= ADV_RST;
      maskReg   <= '0;
      intReg    <= '0;
      linkPrev  <= linkUp;
      forceEval <= 1'b1;
    end else begin
      ctrlReg   <= ctrlN;
      statReg   <= statN;
      advReg    <= advN;
      maskReg   <= maskN;
      intReg    <= intN;
      linkPrev  <= linkUp;
      forceEval <= 1'b0;
    end
  end

  assign phyIrq = |(intReg & maskReg);                // R10
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWe,
  input  logic [CMD_W-1:0]  cmdWdata,
  output logic [CMD_W-1:0]  cmdRdata,
  output logic              doneFlag,
  input  logic              doneClr,
  input  logic              linkUp,
  output logic              phyIrq
);
  mgmtStrobes_t      stb;
  logic [DATA_W-1:0] rdVal;

  mgmt_phy_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWdata(cmdWdata),
    .doneClr(doneClr), .rdVal(rdVal), .stb(stb), .cmdReg(cmdRdata),
    .doneFlag(doneFlag)
  );

  mgmt_phy_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .linkUp(linkUp),
    .rdVal(rdVal), .phyIrq(phyIrq)
  );
endmodule

// File: rtl/mgmt_phy_regs_chk.sv
module mgmt_phy_regs_chk
  import mgmt_phy_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cmdWe,
  input logic [CMD_W-1:0] cmdRdata,
  input logic             doneFlag,
  input logic             doneClr,
  input logic             linkUp,
  input logic             phyIrq
);
  AST_DONE_DUE: assert property (@(posedge clk) disable iff (!rstN)
    cmdWe |-> ##2 doneFlag);                                   // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !doneClr) |=> doneFlag);                      // R2
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(cmdWe, 2));                      // R2
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWe && !$past(cmdWe)) |=> $stable(cmdRdata));          // R1
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyIrq) |-> (($past(linkUp) != $past(linkUp, 2)) || $past(cmdWe, 2))); // R10
endmodule

bind mgmt_phy_regs mgmt_phy_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdRdata(cmdRdata),
  .doneFlag(doneFlag), .doneClr(doneClr), .linkUp(linkUp), .phyIrq(phyIrq)
);

// File: tb/mgmt_phy_regs_test.sv
module mgmt_phy_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWe = 1'b0;
  logic [31:0] cmdWdata = '0;
  logic [31:0] cmdRdata;
  logic        doneFlag;
  logic        doneClr = 1'b0;
  logic        linkUp = 1'b0;
  logic        phyIrq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        seenDone = 1'b0;

  always #5 clk = ~clk;

  mgmt_phy_regs uut (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWdata(cmdWdata),
    .cmdRdata(cmdRdata), .doneFlag(doneFlag), .doneClr(doneClr),
    .linkUp(linkUp), .phyIrq(phyIrq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdCmd(input int n);
    return 32'h2000_0000 | (32'(n) << 18);
  endfunction
  function automatic logic [31:0] wrCmd(input int n, input logic [15:0] d);
    return (32'(n) << 18) | {16'h0, d};
  endfunction

  // monitor: one comparison per completion
  always @(negedge clk) begin
    if (rstN && doneFlag && !seenDone) begin
      seenDone <= 1'b1;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected completion actual=0x%08h expected=none", cmdRdata);
      end else begin
        check(cmdRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end else if (!doneFlag) begin
      seenDone <= 1'b0;
    end
  end

  task automatic issue(input logic [31:0] word, input logic [31:0] exp, input string tag, input bit clr = 1);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk); cmdWe = 1'b1; cmdWdata = word;
    @(negedge clk); cmdWe = 1'b0;
    @(negedge clk);
    if (clr) begin
      doneClr = 1'b1;
      @(negedge clk); doneClr = 1'b0;
    end
  endtask

  task automatic rd(input int n, input logic [15:0] exp, input string tag);
    issue(rdCmd(n), {16'h0, exp}, tag);
  endtask
  task automatic wr(input int n, input logic [15:0] d, input string tag);
    issue(wrCmd(n, d), wrCmd(n, d), tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({31'h0, doneFlag}, 32'h0, "R3 done in reset");
    check(cmdRdata, 32'h0, "R3 cmd in reset");
    check({31'h0, phyIrq}, 32'h0, "R3 irq in reset");
    rstN = 1'b1;
    @(negedge clk);

    rd(0, 16'h3000, "R3 ctrl reset");
    rd(1, 16'h7809, "R3 status reset");
    rd(4, 16'h01E1, "R3 adv reset");
    rd(30, 16'h0000, "R3 mask reset");
    rd(2, 16'h0007, "R4 id1");
    rd(3, 16'hC0D1, "R4 id2");
    rd(5, 16'h0F71, "R4 partner");
    rd(6, 16'h0001, "R4 expansion");
    rd(29, 16'h0010, "R9 down posted after reset");
    rd(29, 16'h0000, "R8 cleared by read");

    wr(17, 16'hFFFF, "R1 write echo");
    rd(17, 16'h0000, "R5 reg17");
    rd(18, 16'h0000, "R5 reg18");
    rd(27, 16'h0000, "R5 reg27");
    rd(31, 16'h0000, "R5 reg31");
    rd(7, 16'h0000, "R5 reg7");
    wr(32, 16'h0000, "R5 out of range write echo");
    rd(32, 16'h0000, "R5 out of range read");
    rd(0, 16'h3000, "R5 no alias onto ctrl");

    wr(4, 16'hFFFF, "R7 adv write");
    rd(4, 16'h2DFF, "R7 adv masked");
    wr(4, 16'h0000, "R7 adv write zero");
    rd(4, 16'h0080, "R7 adv forced bit");
    wr(30, 16'hFFFF, "R7 mask write");
    rd(30, 16'h00FF, "R7 mask masked");

    wr(0, 16'h7FFF, "R6 ctrl write");
    rd(0, 16'h7980, "R6 ctrl masked");
    rd(1, 16'h7829, "R6 autoneg sets status bit5");

    // link up: mask is 0xFF
    check({31'h0, phyIrq}, 32'h0, "R10 irq low with no sources");
    linkUp = 1'b1;
    @(negedge clk);
    check({31'h0, phyIrq}, 32'h1, "R10 irq on link up");
    repeat (4) @(negedge clk);
    rd(29, 16'h00C0, "R9 up bits once");
    rd(29, 16'h0000, "R9 no repost while steady");
    check({31'h0, phyIrq}, 32'h0, "R10 irq low after clear");
    rd(1, 16'h782D, "R9 status up");

    linkUp = 1'b0;
    @(negedge clk);
    rd(1, 16'h7809, "R9 status down");
    rd(29, 16'h0010, "R9 down bit");

    wr(30, 16'h0010, "R7 mask down only");
    linkUp = 1'b1;
    @(negedge clk);
    check({31'h0, phyIrq}, 32'h0, "R10 masked sources");
    linkUp = 1'b0;
    @(negedge clk);
    check({31'h0, phyIrq}, 32'h1, "R10 unmasked source");
    rd(29, 16'h00D0, "R8 read all pending");
    check({31'h0, phyIrq}, 32'h0, "R10 irq after read clear");

    // soft reset with link up
    linkUp = 1'b1;
    @(negedge clk);
    rd(29, 16'h00C0, "R9 up again");
    wr(0, 16'h8000, "R6 soft reset echo");
    rd(0, 16'h3000, "R6 ctrl back to reset");
    rd(4, 16'h01E1, "R6 adv back to reset");
    rd(30, 16'h0000, "R6 mask back to reset");
    rd(1, 16'h782D, "R6 link re-evaluated");
    rd(29, 16'h00C0, "R6 link bits reposted");

    // completion flag persistence
    issue(rdCmd(2), 32'h0000_0007, "R2 sticky read", 0);
    repeat (5) @(negedge clk);
    check({31'h0, doneFlag}, 32'h1, "R2 flag held");
    doneClr = 1'b1;
    @(negedge clk); doneClr = 1'b0;
    check({31'h0, doneFlag}, 32'h0, "R2 flag cleared");
    check(cmdRdata, 32'h0000_0007, "R1 result held");

    repeat (3) @(negedge clk);
    check(expQ.size(), 32'h0, "R2 all completions seen");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule